// File: doc/BRIEF.md
# Multi-Mode Banked Address Mapper

This block turns a 16-bit logical address into a 19-bit physical address for a 512 kB memory. The logical address comes either from the program counter or from a data pointer. Microcode control inputs choose how the three physical bits above the 64 kB boundary are formed. The modes are register, table/zero-page, native, application, kernel-slot-1, kernel-slot-3 and linear. The address path is purely combinational, so the output follows its inputs within the same cycle.

Two bank registers set the bank in the software-driven modes. The data bank register holds a 3-bit bank and a 2-bit block number. The code bank register holds the two top physical bits used for program fetches. Each register is loaded from the write bus in one clock edge.

The 64 kB logical space is split into four 16 kB slots by logical bits 15:14. The kernel modes use that split to map one slot into any 16 kB block of the whole memory.

Top module: `banked_addr_mapper`

## Requirements
- R1: A synchronous active-low reset clears both bank registers to zero. With reset applied and then released, an application-mode data access therefore has physical bits 18:16 equal to 0.
- R2: When `dbank_we` is 1 at a rising edge, the data bank register takes `wr_data[4:0]`: bits 2:0 are the bank and bits 4:3 are the block. When `cbank_we` is 1, the code bank register takes `wr_data[1:0]`. A register whose write enable is 0 keeps its value.
- R3: Register mode (`reg_mode`=1) gives `{11'b0, la[7:0]}`, whatever the bank registers and the other controls hold.
- R4: Table mode (`tbl_mode`=1, `reg_mode`=0) gives `{1'b0, tbl_hi[1:0], 8'b0, la[7:0]}`.
- R5: Native mode gives `{1'b0, uc_bank[1:0], la[15:0]}`, so physical bit 18 is always 0.
- R6: Application mode (`grp_mode`=1, `appl`=1) gives `{dbank[2:0], la}` for data. For code it gives `{cbank[1], dbank[1:0], la}`, unless linear code mode applies.
- R7: Kernel-slot-1 mode (`grp_mode`=1, `appl`=0, `slot3`=0) behaves as follows for both sources. When `la[15:14]`=01 the result is `{dbank[2:0], dbank[4:3], la[13:0]}`. Otherwise it is `{1'b0, uc_bank, la}`.
- R8: Kernel-slot-3 mode (`appl`=0, `slot3`=1) substitutes as in R7 only for data accesses with `la[15:14]`=11. Code accesses always give `{1'b0, uc_bank, la}`.
- R9: Linear code mode (`grp_mode`=1, `appl`=1, `lin_code`=1, code source) gives `{cbank[1:0], uc_bank[0], la}`. With `lin_code`=1, data accesses still follow R6, and the kernel modes ignore `lin_code`.
- R10: The mode priority is register, then table, then native, then the group. When none of `reg_mode`, `tbl_mode`, `nat_mode` and `grp_mode` is set, native behaviour (R5) applies.
- R11: `use_dp`=1 takes the logical address from `dp_addr`, and `use_dp`=0 takes it from `pc_addr`.
- R12: Physical bits 7:0 always equal bits 7:0 of the selected logical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_addr | input | 16 | Program-counter logical address |
| dp_addr | input | 16 | Data-pointer logical address |
| use_dp | input | 1 | 1 selects the data pointer, 0 the program counter |
| reg_mode | input | 1 | Register mode select |
| tbl_mode | input | 1 | Table/zero-page mode select |
| tbl_hi | input | 2 | Physical bits 17:16 in table mode |
| nat_mode | input | 1 | Native mode select |
| uc_bank | input | 2 | Microcode bank bits |
| grp_mode | input | 1 | Selects the application/kernel/linear group |
| appl | input | 1 | Application flag |
| slot3 | input | 1 | Kernel slot select: 1 for slot 3, 0 for slot 1 |
| lin_code | input | 1 | Linear mapping for code fetches |
| dbank_we | input | 1 | Data bank register write enable |
| cbank_we | input | 1 | Code bank register write enable |
| wr_data | input | 8 | Register write bus |
| phys_addr | output | 19 | Physical address |

## Verification
Some properties are checked by assertions on every cycle. Register mode must clear physical bits 18:8, native mode must keep bit 18 at zero, and the low byte must match the selected source. Kernel-slot-3 code fetches must never leave their logical 64 kB window. Each register must load on a write and hold otherwise. Two things can only be shown by the bench's scenarios against its reference function: the full address in every mode, including slot substitution at the slot edges (3FFF/4000, 7FFF/8000, BFFF/C000), and the effect of earlier register writes on later accesses.

// File: rtl/amap_pkg.sv
package amap_pkg;
    localparam int LA_W    = 16;                 // logical address width
    localparam int PA_W    = 19;                 // physical address width
    localparam int LOW_W   = 8;                  // bits kept in register/table mode
    localparam int BANK_W  = PA_W - LA_W;        // 3 bank bits
    localparam int BLK_W   = 2;                  // 16 kB block number width
    localparam int OFS_W   = LA_W - BLK_W;       // offset inside a slot
    localparam int UC_W    = BANK_W - 1;         // microcode bank bits
    localparam int DB_W    = BANK_W + BLK_W;     // data bank register width
    localparam int CB_W    = BANK_W - 1;         // code bank register width
    localparam int WD_W    = 8;                  // write bus width

    typedef enum logic [2:0] {
        M_REG, M_TBL, M_NAT, M_APP, M_KS1, M_KS3, M_LIN
    } amode_e;
endpackage

// File: rtl/amap_bank_reg.sv
// Bank select register with a one-cycle load from the write bus.
// Assumes a synchronous active-low reset that clears it to zero.
module amap_bank_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Holds the bank value; loads on write, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(d));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $past(rst_n)) |=> $stable(q));
endmodule

// File: rtl/amap_mode_dec.sv
// Decodes the microcode controls into one addressing mode by fixed priority.
// Assumes the controls are stable within the cycle; no storage.
module amap_mode_dec
    import amap_pkg::*;
(
    input  logic   reg_mode,
    input  logic   tbl_mode,
    input  logic   nat_mode,
    input  logic   grp_mode,
    input  logic   appl,
    input  logic   slot3,
    input  logic   lin_code,
    input  logic   use_dp,
    output amode_e mode
);
    // Priority: register, table, native, group; otherwise native.
    always_comb begin
        if (reg_mode)      mode = M_REG;
        else if (tbl_mode) mode = M_TBL;
        else if (nat_mode) mode = M_NAT;
        else if (grp_mode) begin
            if (appl)       mode = (lin_code && !use_dp) ? M_LIN : M_APP;
            else if (slot3) mode = M_KS3;
            else            mode = M_KS1;
        end
        else               mode = M_NAT;
    end
endmodule

// File: rtl/amap_addr_mux.sv
// Forms the physical address from the decoded mode, the logical address,
// the bank registers and the microcode bits. Purely combinational; clock
// and reset are used only by the assertions.
module amap_addr_mux
    import amap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  amode_e            mode,
    input  logic              use_dp,
    input  logic [LA_W-1:0]   la,
    input  logic [DB_W-1:0]   dbank,
    input  logic [CB_W-1:0]   cbank,
    input  logic [UC_W-1:0]   uc_bank,
    input  logic [1:0]        tbl_hi,
    output logic [PA_W-1:0]   pa
);
    localparam logic [BLK_W-1:0] SLOT1 = 2'b01;
    localparam logic [BLK_W-1:0] SLOT3 = 2'b11;

    logic [BLK_W-1:0]  slot;
    logic              sub_hit;
    logic [BANK_W-1:0] d_bank;
    logic [BLK_W-1:0]  d_blk;

    assign slot   = la[LA_W-1 -: BLK_W];
    assign d_bank = dbank[BANK_W-1:0];
    assign d_blk  = dbank[DB_W-1 -: BLK_W];

    // Detects whether the kernel modes swap in the register's bank and block.
    always_comb begin
        case (mode)
            M_KS1:   sub_hit = (slot == SLOT1);
            M_KS3:   sub_hit = use_dp && (slot == SLOT3);
            default: sub_hit = 1'b0;
        endcase
    end

    // Selects the upper bits per mode and passes the offset through.
    always_comb begin
        case (mode)
            M_REG: pa = {{(PA_W-LOW_W){1'b0}}, la[LOW_W-1:0]};
            M_TBL: pa = {1'b0, tbl_hi, {(LA_W-LOW_W){1'b0}}, la[LOW_W-1:0]};
            M_APP: pa = use_dp ? {d_bank, la}
                               : {cbank[CB_W-1], d_bank[BANK_W-2:0], la};
            M_LIN: pa = {cbank, uc_bank[0], la};
            M_KS1, M_KS3:
                pa = sub_hit ? {d_bank, d_blk, la[OFS_W-1:0]}
                             : {1'b0, uc_bank, la};
            default: pa = {1'b0, uc_bank, la};
        endcase
    end

    // R3
    reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_REG) |-> pa[PA_W-1:LOW_W] == '0);
    // R5
    native_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_NAT) |-> !pa[PA_W-1]);
    // R8
    ks3_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_KS3 && !use_dp) |-> pa[LA_W-1:0] == la);
    // R12
    low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pa[LOW_W-1:0] == la[LOW_W-1:0]);
endmodule

// File: rtl/banked_addr_mapper.sv
// Top of the banked address mapper: selects the logical source, decodes
// the mode, holds the two bank registers and muxes the physical address.
// Assumes microcode controls and addresses are valid for the whole cycle.
module banked_addr_mapper
    import amap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      pc_addr,
    input  logic [15:0]      dp_addr,
    input  logic             use_dp,
    input  logic             reg_mode,
    input  logic             tbl_mode,
    input  logic [1:0]       tbl_hi,
    input  logic             nat_mode,
    input  logic [1:0]       uc_bank,
    input  logic             grp_mode,
    input  logic             appl,
    input  logic             slot3,
    input  logic             lin_code,
    input  logic             dbank_we,
    input  logic             cbank_we,
    input  logic [7:0]       wr_data,
    output logic [18:0]      phys_addr
);
    logic [LA_W-1:0] la;
    logic [DB_W-1:0] dbank_q;
    logic [CB_W-1:0] cbank_q;
    amode_e          mode;

    // Picks the logical address source.
    assign la = use_dp ? dp_addr : pc_addr;

    amap_bank_reg #(.W(DB_W)) u_dbank (
        .clk(clk), .rst_n(rst_n), .we(dbank_we),
        .d(wr_data[DB_W-1:0]), .q(dbank_q)
    );

    amap_bank_reg #(.W(CB_W)) u_cbank (
        .clk(clk), .rst_n(rst_n), .we(cbank_we),
        .d(wr_data[CB_W-1:0]), .q(cbank_q)
    );

    amap_mode_dec u_dec (
        .reg_mode(reg_mode), .tbl_mode(tbl_mode), .nat_mode(nat_mode),
        .grp_mode(grp_mode), .appl(appl), .slot3(slot3),
        .lin_code(lin_code), .use_dp(use_dp), .mode(mode)
    );

    amap_addr_mux u_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode), .use_dp(use_dp), .la(la),
        .dbank(dbank_q), .cbank(cbank_q), .uc_bank(uc_bank),
        .tbl_hi(tbl_hi), .pa(phys_addr)
    );

    // R11
    src_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[7:0] == (use_dp ? dp_addr[7:0] : pc_addr[7:0]));
    // R10
    reg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode |-> phys_addr[18:8] == 11'd0);
endmodule

// File: tb/banked_addr_mapper_tb_top.sv
`timescale 1ns/1ps
module banked_addr_mapper_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] pc_addr = '0, dp_addr = '0;
    logic use_dp = 0, reg_mode = 0, tbl_mode = 0, nat_mode = 0, grp_mode = 0;
    logic appl = 0, slot3 = 0, lin_code = 0, dbank_we = 0, cbank_we = 0;
    logic [1:0] tbl_hi = '0, uc_bank = '0;
    logic [7:0] wr_data = '0;
    logic [18:0] phys_addr;

    int checks = 0, failures = 0;
    logic [4:0] m_d = '0;
    logic [1:0] m_c = '0;

    always #2.5 clk = ~clk;

    banked_addr_mapper dut_i (.*);

    // Reference model of the requirements.
    function automatic logic [18:0] ref_pa(output string tag);
        logic [15:0] a;
        a = use_dp ? dp_addr : pc_addr;
        if (reg_mode) begin tag = "R3"; return {11'd0, a[7:0]}; end
        if (tbl_mode) begin tag = "R4"; return {1'b0, tbl_hi, 8'd0, a[7:0]}; end
        if (nat_mode || !grp_mode) begin tag = "R5/R10"; return {1'b0, uc_bank, a}; end
        if (appl) begin
            if (!use_dp && lin_code) begin tag = "R9"; return {m_c, uc_bank[0], a}; end
            tag = "R6";
            return use_dp ? {m_d[2:0], a} : {m_c[1], m_d[1:0], a};
        end
        if (!slot3) begin
            tag = "R7";
            if (a[15:14] == 2'b01) return {m_d[2:0], m_d[4:3], a[13:0]};
            return {1'b0, uc_bank, a};
        end
        tag = "R8";
        if (use_dp && a[15:14] == 2'b11) return {m_d[2:0], m_d[4:3], a[13:0]};
        return {1'b0, uc_bank, a};
    endfunction

    task automatic check_now(string extra);
        string tag;
        logic [18:0] exp;
        exp = ref_pa(tag);
        checks++;
        if (phys_addr !== exp) begin
            failures++;
            $display("FAIL %s %s (R11/R12) actual=%h expected=%h", tag, extra, phys_addr, exp);
        end
    endtask

    task automatic set_ctl(input logic r, t, n, g, ap, s3, lc, dp);
        reg_mode = r; tbl_mode = t; nat_mode = n; grp_mode = g;
        appl = ap; slot3 = s3; lin_code = lc; use_dp = dp;
    endtask

    // Writes registers through the bus (R2) and updates the model.
    task automatic wr_regs(input logic wd, wc, input logic [7:0] v);
        @(negedge clk);
        dbank_we = wd; cbank_we = wc; wr_data = v;
        @(negedge clk);
        if (wd) m_d = v[4:0];
        if (wc) m_c = v[1:0];
        dbank_we = 0; cbank_we = 0; wr_data = 8'hA5;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: application data after reset uses bank 0
        set_ctl(0,0,0,1,1,0,0,1); dp_addr = 16'hC123;
        #1 check_now("R1 reset");
        wr_regs(1, 1, 8'b000_11_101);
        set_ctl(0,0,0,1,1,0,0,1); #1 check_now("R2 R6 data");
        set_ctl(0,0,0,1,1,0,0,0); pc_addr = 16'h1234; #1 check_now("R6 code");
        // R2 hold: write only code reg, data unchanged
        wr_regs(0, 1, 8'hFE);
        set_ctl(0,0,0,1,1,0,0,1); #1 check_now("R2 hold");
        set_ctl(0,0,0,1,1,0,1,0); uc_bank = 2'b01; #1 check_now("R9 linear code");
        set_ctl(0,0,0,1,1,0,1,1); #1 check_now("R9 linear data");
        // R7 slot edges
        foreach (dp_addr[i]) if (i < 1) begin end
        for (int k = 0; k < 6; k++) begin
            logic [15:0] e [6] = '{16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000};
            set_ctl(0,0,0,1,0,0,0,k[0]); pc_addr = e[k]; dp_addr = e[k];
            #1 check_now("R7 edge");
            set_ctl(0,0,0,1,0,1,0,1); #1 check_now("R8 data edge");
            set_ctl(0,0,0,1,0,1,1,0); #1 check_now("R8 code edge");
        end
        set_ctl(1,1,1,1,1,1,1,1); #1 check_now("R3 priority");
        set_ctl(0,1,1,0,0,0,0,0); tbl_hi = 2'b10; #1 check_now("R4");
        set_ctl(0,0,1,1,1,0,0,1); #1 check_now("R5");
        set_ctl(0,0,0,0,1,1,1,1); #1 check_now("R10 fallback");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            pc_addr = 16'($urandom); dp_addr = 16'($urandom);
            set_ctl(($urandom%8)==0, ($urandom%6)==0, ($urandom%6)==0,
                    ($urandom%5)!=0, 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            tbl_hi = 2'($urandom); uc_bank = 2'($urandom);
            dbank_we = ($urandom%4)==0; cbank_we = ($urandom%4)==0;
            wr_data = 8'($urandom);
            #1 check_now("random");
            if (dbank_we) m_d = wr_data[4:0];
            if (cbank_we) m_c = wr_data[1:0];
        end
        @(negedge clk);
        dbank_we = 0; cbank_we = 0;
        #1 check_now("final");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule